// File: doc/BRIEF.md
# SPI Memory-Mapped Access Master

This block is an SPI master that turns requests from a local host into framed transactions for a display coprocessor. The coprocessor exposes a flat 22-bit byte address space. The host presents one request at a time on a valid/ready handshake. A request carries an opcode, an address, a byte count and a 32-bit word. The master then runs a whole frame under one chip-select assertion: it sends a three-byte address header whose leading bits give the direction, then the payload.

The request types are:
- single read and single write of up to four bytes, taken from or returned in a 32-bit word, least significant byte first;
- burst read and burst write of any length, streamed through byte-wide valid/ready channels;
- a three-byte host command.

A request is accepted only while the master is idle. `req_ready` is high exactly in that state.

On a burst write, the master takes a byte only when `bw_valid` is high. While no byte is offered, it leaves SCLK low between bytes. On a burst read, it does not start the next byte while the previous byte is still held in the output register with `br_ready` low. So back-pressure on either channel stretches the frame and loses no data. A one-cycle `done` pulse marks the end of every frame. For single reads, `rd_word` holds the result from that pulse until the next request is accepted.

Top module: `spi_mem_master`

## Requirements
- R1: SPI mode 0. SCLK idles low and is low whenever `cs_n` is high. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge. Every byte is shifted most significant bit first.
- R2: A write frame (opcode 1 or 3) starts with three header bytes: {2'b10, addr[21:16]}, addr[15:8], addr[7:0].
- R3: A read frame (opcode 0 or 2) starts with {2'b00, addr[21:16]}, addr[15:8], addr[7:0], then one dummy byte 0x00. MOSI carries 0x00 for every data byte that follows.
- R4: A single write (opcode 1) sends `req_wdata` least significant byte first, for min(`req_len`, 4) bytes.
- R5: A single read (opcode 0) receives min(`req_len`, 4) bytes. The first byte received goes into `rd_word[7:0]`, the next into `rd_word[15:8]`, and so on. Bytes not received read as zero.
- R6: A host command (opcode 4; opcodes 5 to 7 are treated the same) is exactly three bytes: `req_wdata[7:0]`, 0x00, 0x00. It has no data phase.
- R7: A burst write (opcode 3) sends exactly `req_len` bytes, in order, from the `bw_*` channel. `bw_ready` is high only in a cycle where `bw_valid` is high and the byte is being launched.
- R8: A burst read (opcode 2) delivers exactly `req_len` bytes, in order, on the `br_*` channel. While `br_valid` is high and `br_ready` is low, `br_valid` and `br_data` hold.
- R9: SCLK high and low phases each last DIV_FAST clock cycles if `fast_sel` was high when the request was accepted, and DIV_SLOW cycles otherwise. Changing `fast_sel` during a frame has no effect on that frame.
- R10: `cs_n` stays high for at least two SCLK half-periods of the previous frame before the next frame starts. `req_ready` is high only while `cs_n` is high.
- R11: `done` is a single-cycle pulse that coincides with the rise of `cs_n` at the end of each frame.
- R12: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `req_ready` is 1, and `done` and `br_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_sel | input | 1 | Selects the fast SCLK rate; sampled when a request is accepted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request accepted this cycle if valid |
| req_op | input | 3 | 0 read, 1 write, 2 burst read, 3 burst write, 4 host command |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Data byte count |
| req_wdata | input | 32 | Single-write word, or command byte in bits 7:0 |
| bw_valid | input | 1 | Burst write byte offered |
| bw_ready | output | 1 | Burst write byte taken |
| bw_data | input | 8 | Burst write byte |
| br_valid | output | 1 | Burst read byte available |
| br_ready | input | 1 | Burst read byte consumer ready |
| br_data | output | 8 | Burst read byte |
| done | output | 1 | End-of-frame pulse |
| rd_word | output | 32 | Single-read result |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data in |

## Verification
A bit-level slave model records each MOSI byte and answers with a position-dependent byte pattern, so header, dummy and payload bytes can each be told apart. Directed frames cover the limits:
- the top address;
- lengths of 0, 4 and above 4;
- a host command from an out-of-range opcode;
- long back-pressure stalls on both burst channels.

Seeded random requests then mix opcodes, lengths, rates and channel stalls. Toggling `fast_sel` in mid-frame, and measuring every SCLK high phase and every chip-select gap, separates a rate that is latched per frame from one that follows the pin.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_BRD  = 3'd2,
    OP_BWR  = 3'd3,
    OP_HCMD = 3'd4
  } spim_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HDR,
    S_DATA,
    S_GAP
  } spim_state_e;
endpackage

// File: rtl/spim_byte_eng.sv
// Shifts one byte in SPI mode 0, MSB first, with a programmable half period.
module spim_byte_eng #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_cyc,
  input  logic          start,
  input  logic [7:0]    tx,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx
);
  localparam logic [HW-1:0] ONE = HW'(1);

  logic [HW-1:0] cnt;
  logic [2:0]    bitc;
  logic [7:0]    sh, rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; cnt <= '0; bitc <= '0;
      sh <= '0; rxs <= '0; rx <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh <= tx; cnt <= '0; bitc <= '0; sclk <= 1'b0;
        end
      end else if (cnt == half_cyc - ONE) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rxs  <= {rxs[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitc == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
            rx   <= rxs;
          end else begin
            bitc <= bitc + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign mosi = busy & sh[7];

  // R1: data on MOSI is settled before the rising edge
  a_r1_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R1: SCLK only toggles inside a byte
  a_r1_sclk_within_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);
endmodule

// File: rtl/spim_hdr.sv
// Selects the header byte for a given position and opcode.
module spim_hdr
  import spim_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  spim_op_e          op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  input  logic [1:0]        idx,
  output logic [7:0]        hdr_byte,
  output logic [1:0]        last_idx
);
  logic [23:0] a24;
  assign a24 = {{(24-ADDR_W){1'b0}}, addr};

  always_comb begin
    hdr_byte = 8'h00;
    last_idx = 2'd2;
    unique case (op)
      OP_WR, OP_BWR: begin
        unique case (idx)
          2'd0:    hdr_byte = a24[23:16] | 8'h80;
          2'd1:    hdr_byte = a24[15:8];
          default: hdr_byte = a24[7:0];
        endcase
      end
      OP_RD, OP_BRD: begin
        last_idx = 2'd3;
        unique case (idx)
          2'd0:    hdr_byte = a24[23:16] & 8'h3F;
          2'd1:    hdr_byte = a24[15:8];
          2'd2:    hdr_byte = a24[7:0];
          default: hdr_byte = 8'h00;
        endcase
      end
      default: hdr_byte = (idx == 2'd0) ? cmd : 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_mem_master.sv
module spi_mem_master
  import spim_pkg::*;
#(
  parameter int              ADDR_W   = 22,
  parameter int              LEN_W    = 12,
  parameter int              HW       = 8,
  parameter logic [HW-1:0]   DIV_SLOW = 8'd10,
  parameter logic [HW-1:0]   DIV_FAST = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  input  logic              bw_valid,
  output logic              bw_ready,
  input  logic [7:0]        bw_data,
  output logic              br_valid,
  input  logic              br_ready,
  output logic [7:0]        br_data,
  output logic              done,
  output logic [31:0]       rd_word,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(4);
  localparam logic [HW:0]      GAP_ONE  = (HW+1)'(1);

  spim_state_e       st;
  spim_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wd_q;
  logic [HW-1:0]     half_q;
  logic [LEN_W-1:0]  rem;
  logic [1:0]        hidx, bidx;
  logic              infl;
  logic [HW:0]       gcnt;

  logic       eng_start, eng_busy, eng_done, data_ok;
  logic [7:0] eng_rx, tx_byte, hdr_byte;
  logic [1:0] hdr_last;

  spim_hdr #(.ADDR_W(ADDR_W)) i_hdr (
    .op(op_q), .addr(addr_q), .cmd(wd_q[7:0]), .idx(hidx),
    .hdr_byte(hdr_byte), .last_idx(hdr_last)
  );

  spim_byte_eng #(.HW(HW)) i_eng (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_q), .start(eng_start),
    .tx(tx_byte), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(eng_busy), .done(eng_done), .rx(eng_rx)
  );

  always_comb begin
    unique case (op_q)
      OP_BWR:  data_ok = bw_valid;
      OP_BRD:  data_ok = !br_valid || br_ready;
      default: data_ok = 1'b1;
    endcase
  end

  assign eng_start = !infl && ((st == S_HDR) || ((st == S_DATA) && data_ok));
  assign bw_ready  = (st == S_DATA) && (op_q == OP_BWR) && !infl && bw_valid;
  assign req_ready = (st == S_IDLE);

  always_comb begin
    if (st == S_HDR)          tx_byte = hdr_byte;
    else if (op_q == OP_WR)   tx_byte = wd_q[{bidx, 3'b000} +: 8];
    else if (op_q == OP_BWR)  tx_byte = bw_data;
    else                      tx_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_HCMD; addr_q <= '0; wd_q <= '0;
      half_q <= DIV_SLOW; rem <= '0; hidx <= '0; bidx <= '0;
      infl <= 1'b0; gcnt <= '0; cs_n <= 1'b1; done <= 1'b0;
      rd_word <= '0; br_valid <= 1'b0; br_data <= '0;
    end else begin
      done <= 1'b0;
      if (br_valid && br_ready) br_valid <= 1'b0;
      if (eng_start) infl <= 1'b1;
      unique case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= (req_op > 3'd4) ? OP_HCMD : spim_op_e'(req_op);
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          half_q  <= fast_sel ? DIV_FAST : DIV_SLOW;
          rem     <= ((req_op == OP_RD || req_op == OP_WR) && req_len > LEN_WORD)
                     ? LEN_WORD : req_len;
          hidx    <= '0;
          bidx    <= '0;
          rd_word <= '0;
          cs_n    <= 1'b0;
          st      <= S_HDR;
        end
        S_HDR: if (eng_done) begin
          infl <= 1'b0;
          if (hidx == hdr_last) begin
            if (op_q == OP_HCMD || rem == '0) begin
              st <= S_GAP; cs_n <= 1'b1; done <= 1'b1; gcnt <= '0;
            end else begin
              st <= S_DATA;
            end
          end else begin
            hidx <= hidx + 2'd1;
          end
        end
        S_DATA: if (eng_done) begin
          infl <= 1'b0;
          rem  <= rem - LEN_ONE;
          bidx <= bidx + 2'd1;
          if (op_q == OP_RD) rd_word[{bidx, 3'b000} +: 8] <= eng_rx;
          if (op_q == OP_BRD) begin
            br_valid <= 1'b1;
            br_data  <= eng_rx;
          end
          if (rem == LEN_ONE) begin
            st <= S_GAP; cs_n <= 1'b1; done <= 1'b1; gcnt <= '0;
          end
        end
        default: begin
          gcnt <= gcnt + GAP_ONE;
          if (gcnt == {half_q, 1'b0} - GAP_ONE) st <= S_IDLE;
        end
      endcase
    end
  end

  // R1: clock is parked low outside a frame
  a_r1_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R10: requests are only taken with the slave deselected
  a_r10_accept_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  // R7: a taken write byte is launched at once
  a_r7_take_launches: assert property (@(posedge clk) disable iff (!rst_n)
    bw_ready |=> eng_busy);
  // R8: a stalled read byte holds
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_ready) |=> (br_valid && $stable(br_data)));
  // R11: done marks the chip-select release
  a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $rose(cs_n)));
  // R9: divider never zero during a frame
  a_r9_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (half_q != '0));
endmodule

// File: tb/test_spi_mem_master.sv
`timescale 1ns/1ps
module test_spi_mem_master;
  localparam int SLOW = 10;
  localparam int FAST = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast_sel = 1'b0, req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [21:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic bw_valid = 1'b0, bw_ready;
  logic [7:0] bw_data = '0;
  logic br_valid, br_ready = 1'b0;
  logic [7:0] br_data;
  logic done;
  logic [31:0] rd_word;
  logic sclk, mosi, cs_n;
  logic miso = 1'b0;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  spi_mem_master #(.DIV_SLOW(8'(SLOW)), .DIV_FAST(8'(FAST))) i_spi_mem_master (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .bw_valid(bw_valid),
    .bw_ready(bw_ready), .bw_data(bw_data), .br_valid(br_valid),
    .br_ready(br_ready), .br_data(br_data), .done(done), .rd_word(rd_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + 90);
  endfunction

  // slave model: captures MOSI on rise, shifts out next MISO bit right after
  logic [7:0] fb [0:63];
  int nb = 0, bitn = 0;
  logic [7:0] cur = '0;
  always @(posedge sclk or negedge cs_n) begin
    logic [7:0] r;
    if (sclk) begin
      cur = {cur[6:0], mosi};
      bitn++;
      if (bitn == 8) begin
        if (nb < 64) fb[nb] = cur;
        nb++;
        bitn = 0;
      end
      r = resp(nb);
      miso = r[7 - bitn];
    end else begin
      nb = 0; bitn = 0;
      r = resp(0);
      miso = r[7];
    end
  end

  // rate and gap monitor
  int hi_run = 0, hi_min = 0, hi_max = 0, gap_run = 0, last_gap = 0;
  always @(negedge clk) begin
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_min == 0 || hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (cs_n) gap_run++;
    else if (gap_run > 0) begin
      last_gap = gap_run; gap_run = 0; hi_min = 0; hi_max = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  logic [7:0] bsrc [0:63];
  logic [7:0] brcv [0:63];
  int prev_h = 0;

  task automatic run(input logic [2:0] op, input logic [21:0] addr,
                     input int len, input logic [31:0] wd, input bit fast);
    int bi = 0, ri = 0, elen, n, guard;
    bit got = 0, ok;
    logic [7:0] ex [0:63];
    logic [31:0] exw;
    int h = fast ? FAST : SLOW;
    for (int i = 0; i < len && i < 64; i++) bsrc[i] = 8'($urandom);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_len = 12'(len);
    req_wdata = wd; fast_sel = fast;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    fast_sel = ~fast;
    while (!got) begin
      bw_valid = (op == 3'd3 && bi < len) ? ($urandom % 4 != 0) : 1'b0;
      bw_data  = bsrc[bi];
      br_ready = ($urandom % 3 != 0);
      #1;
      if (bw_valid && bw_ready) bi++;
      if (br_valid && br_ready) begin brcv[ri] = br_data; ri++; end
      if (done) got = 1;
      @(negedge clk);
    end
    bw_valid = 0;
    br_ready = 1;
    guard = 0;
    while (guard < 4) begin
      #1;
      if (br_valid && br_ready) begin brcv[ri] = br_data; ri++; end
      @(negedge clk);
      guard++;
    end
    br_ready = 0;
    // expected frame
    elen = ((op == 3'd0 || op == 3'd1) && len > 4) ? 4 : len;
    n = 0;
    if (op >= 3'd4) begin
      ex[0] = wd[7:0]; ex[1] = 0; ex[2] = 0; n = 3; elen = 0;
    end else if (op == 3'd1 || op == 3'd3) begin
      ex[0] = {2'b10, addr[21:16]}; ex[1] = addr[15:8]; ex[2] = addr[7:0]; n = 3;
      for (int i = 0; i < elen; i++) begin
        ex[n] = (op == 3'd1) ? wd[8*i +: 8] : bsrc[i]; n++;
      end
    end else begin
      ex[0] = {2'b00, addr[21:16]}; ex[1] = addr[15:8]; ex[2] = addr[7:0]; ex[3] = 0; n = 4;
      for (int i = 0; i < elen; i++) begin ex[n] = 8'h00; n++; end
    end
    chk(nb == n, "R2/R3/R6 frame length", nb, n);
    ok = 1;
    for (int i = 0; i < n && i < nb; i++)
      if (fb[i] !== ex[i]) begin
        ok = 0;
        chk(0, (op >= 3'd4) ? "R6 host command byte" :
               (op == 3'd1) ? "R2 R4 write frame byte" :
               (op == 3'd3) ? "R2 R7 burst write byte" : "R3 read frame byte",
            fb[i], ex[i]);
        break;
      end
    if (ok) chk(1, "R1 frame bytes", 0, 0);
    if (op == 3'd0) begin
      exw = '0;
      for (int i = 0; i < elen; i++) exw[8*i +: 8] = resp(4 + i);
      chk(rd_word == exw, "R5 single read word", rd_word, exw);
    end
    if (op == 3'd2) begin
      chk(ri == len, "R8 burst read count", ri, len);
      for (int i = 0; i < ri && i < len; i++)
        if (brcv[i] !== resp(4 + i)) begin
          chk(0, "R8 burst read byte", brcv[i], resp(4 + i)); break;
        end
    end
    if (op == 3'd3) chk(bi == len, "R7 burst write bytes taken", bi, len);
    chk(hi_min == h && hi_max == h, "R9 sclk high phase", hi_max, h);
    if (prev_h > 0) chk(last_gap >= 2 * prev_h, "R10 chip select gap", last_gap, 2 * prev_h);
    prev_h = h;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R12 spi pins at reset", {cs_n, sclk, mosi}, 3'b100);
    chk(req_ready == 1 && done == 0 && br_valid == 0, "R12 handshake at reset",
        {req_ready, done, br_valid}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corner cases
    run(3'd1, 22'h3FFFFF, 4, 32'h11223344, 1'b1);
    run(3'd0, 22'h3FFFFF, 2, 32'h0, 1'b0);
    run(3'd1, 22'h012345, 6, 32'hCAFEF00D, 1'b0);
    run(3'd0, 22'h2A0F0F, 7, 32'h0, 1'b1);
    run(3'd4, 22'h0, 0, 32'h00000068, 1'b0);
    run(3'd7, 22'h0, 3, 32'h000000AB, 1'b1);
    run(3'd3, 22'h100000, 9, 32'h0, 1'b1);
    run(3'd2, 22'h000200, 10, 32'h0, 1'b1);
    run(3'd0, 22'h000004, 0, 32'h0, 1'b1);
    run(3'd3, 22'h000008, 0, 32'h0, 1'b0);
    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [2:0] op = 3'($urandom % 5);
      int len = (op <= 3'd1) ? int'($urandom % 7) : int'($urandom % 13);
      run(op, 22'($urandom), len, $urandom, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule